// File: doc/BRIEF.md
# Memory activity monitor

The block watches bus-transaction event pulses on several channels and turns them into interrupt requests for a frequency-scaling controller. Each cycle in which a channel's event input is high adds that channel's programmable weight to a per-period counter. A shared period generator cuts time into sampling periods built from an external millisecond tick. At every period boundary each channel takes its period count as a sample, folds it into an exponential moving average and compares both the sample and the new average against programmable watermarks.

Two kinds of trigger set status flags. A hysteresis run counter fires when the raw sample has been above the upper watermark, or below the lower one, for a programmed number of periods in a row. A band check fires when the moving average leaves its own window. Each of the four triggers has its own enable. Software programs and reads the block through a simple word register port with a one-cycle read latency. A global status word shows which channel is requesting service.

Top module: `activity_monitor`

## Requirements
- R1: While a channel is active, every cycle with its event input high adds its weight register (offset 0x18) to the period count, saturating at all ones. At a boundary the sample is the count including that cycle's event, and the count restarts at zero.
- R2: The period register (global offset 0x4, 8 bits) holds the number of ticks per period minus one. A boundary occurs on the tick that arrives when the tick counter equals that value; writing the register restarts the tick counter.
- R3: At each boundary of an active channel the average becomes avg + floor((sample - avg) / 2^(K+1)), where K is control bits 12:10. The average is read at offset 0x20.
- R4: Control bits 28:26 hold N-1 for the upper run. When the sample is strictly above the upper watermark (offset 0x4) for N boundaries in a row, status bit 31 sets if control bit 30 is 1. The run restarts from zero after it fires and after any period that does not breach.
- R5: Control bits 25:23 hold N-1 for the lower run. When the sample is strictly below the lower watermark (offset 0x8) for N boundaries in a row, status bit 30 sets if control bit 29 is 1. The run restarts in the same way as in R4.
- R6: After the average update, an average strictly above the band top (offset 0x10) sets status bit 29 if control bit 21 is 1. An average strictly below the band bottom (offset 0x14) sets status bit 28 if control bit 20 is 1.
- R7: Writing the status register (offset 0x24) clears every bit written as one. A flag that hardware sets in the same cycle wins.
- R8: Writing offset 0xC loads the moving average directly.
- R9: A channel is active only when control bit 31 (enable) and bit 18 (periodic) are both 1. Writing zero to the control word stops the channel: events and boundaries are then ignored, the count and runs stay cleared and the average holds.
- R10: The irq output is registered, one cycle behind the OR over all channels of the status bits whose enable is currently set. The global status word (offset 0x0) shows channel c's masked request on bit 26-c.
- R11: After reset every register, the average, the status, irq and reg_rdata are zero. Channel c's registers are at 0x1C0 + 0x40*c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| event_i | input | NCH | Per-channel weighted event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the previous cycle's address |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong average or a wrong run count does not stay hidden. It shows up at the very next boundary as a read value that differs from the floor-division model, or as a status flag set one period early or late. A faulty mask or clear path shows up on irq one cycle after the register write that should change it. The stimulus table walks a single channel through fire, restart and non-breach periods with odd differences, so that rounding toward minus infinity is exercised. Directed cases cover the band flags, a larger K, the stopped channel, the second channel's global bit and a multi-tick period.

// File: rtl/amon_pkg.sv
`timescale 1ns/1ps
package amon_pkg;
  localparam int REG_W        = 32;
  localparam int RUN_W        = 3;
  localparam int K_W          = 3;
  // control word fields
  localparam int K_LSB        = 10;
  localparam int PERIODIC_BIT = 18;
  localparam int AVG_LO_EN    = 20;
  localparam int AVG_HI_EN    = 21;
  localparam int RUN_LO_LSB   = 23;
  localparam int RUN_HI_LSB   = 26;
  localparam int RUN_LO_EN    = 29;
  localparam int RUN_HI_EN    = 30;
  localparam int CH_EN_BIT    = 31;
  // per-channel offsets
  localparam logic [5:0] OFF_CTRL = 6'h00;
  localparam logic [5:0] OFF_HI   = 6'h04;
  localparam logic [5:0] OFF_LO   = 6'h08;
  localparam logic [5:0] OFF_INIT = 6'h0C;
  localparam logic [5:0] OFF_AHI  = 6'h10;
  localparam logic [5:0] OFF_ALO  = 6'h14;
  localparam logic [5:0] OFF_WT   = 6'h18;
  localparam logic [5:0] OFF_AVG  = 6'h20;
  localparam logic [5:0] OFF_STAT = 6'h24;
  // global offsets
  localparam logic [5:0] OFF_GSTAT = 6'h00;
  localparam logic [5:0] OFF_GPER  = 6'h04;
  localparam int CH_BASE  = 'h1C0;
  localparam int BLK_LSB  = 6;
  localparam int GBIT0    = 26;

  // status flags occupy bits 31:28 in this order
  typedef struct packed {
    logic run_hi;
    logic run_lo;
    logic avg_hi;
    logic avg_lo;
  } amon_flags_t;
endpackage

// File: rtl/amon_period.sv
`timescale 1ns/1ps
module amon_period #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PER_W-1:0] wdata,
  input  logic             ms_tick,
  output logic             boundary,
  output logic [PER_W-1:0] per_q,
  output logic [PER_W-1:0] cnt_q
);
  assign boundary = ms_tick && (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      per_q <= wdata;
      cnt_q <= '0;
    end else if (ms_tick) begin
      cnt_q <= boundary ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/amon_channel.sv
`timescale 1ns/1ps
module amon_channel
  import amon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [5:0]       wr_off,
  input  logic [REG_W-1:0] wdata,
  input  logic [5:0]       rd_off,
  input  logic             boundary,
  input  logic             event_i,
  output logic [REG_W-1:0] rd_val,
  output logic             pend,
  output logic             active,
  output logic [REG_W-1:0] count_o,
  output logic [3:0]       stat_o
);
  logic [REG_W-1:0] ctrl_q, hi_q, lo_q, ahi_q, alo_q, wt_q, avg_q, cnt_q;
  amon_flags_t      flags_q, flags_set, flags_clr, flags_mask;
  logic [RUN_W:0]   run_hi_q, run_lo_q;

  logic [REG_W-1:0]      inc, sample, avg_nxt;
  logic [REG_W:0]        sum;
  logic signed [REG_W:0] diff, step;
  logic [K_W:0]          kshift;
  logic [RUN_W:0]        hi_need, lo_need, hi_inc, lo_inc;
  logic above, below, hi_fire, lo_fire;

  assign active = ctrl_q[CH_EN_BIT] & ctrl_q[PERIODIC_BIT];

  always_comb begin
    inc    = event_i ? wt_q : '0;
    sum    = {1'b0, cnt_q} + {1'b0, inc};
    sample = sum[REG_W] ? '1 : sum[REG_W-1:0];
    kshift = {1'b0, ctrl_q[K_LSB +: K_W]} + 1'b1;
    diff   = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
    step   = diff >>> kshift;
    avg_nxt = avg_q + step[REG_W-1:0];

    above   = sample > hi_q;
    below   = sample < lo_q;
    hi_need = {1'b0, ctrl_q[RUN_HI_LSB +: RUN_W]} + 1'b1;
    lo_need = {1'b0, ctrl_q[RUN_LO_LSB +: RUN_W]} + 1'b1;
    hi_inc  = run_hi_q + 1'b1;
    lo_inc  = run_lo_q + 1'b1;
    hi_fire = above && (hi_inc == hi_need);
    lo_fire = below && (lo_inc == lo_need);

    flags_mask = '{run_hi: ctrl_q[RUN_HI_EN], run_lo: ctrl_q[RUN_LO_EN],
                   avg_hi: ctrl_q[AVG_HI_EN], avg_lo: ctrl_q[AVG_LO_EN]};
    flags_set = '0;
    if (active && boundary) begin
      flags_set.run_hi = hi_fire;
      flags_set.run_lo = lo_fire;
      flags_set.avg_hi = avg_nxt > ahi_q;
      flags_set.avg_lo = avg_nxt < alo_q;
      flags_set = flags_set & flags_mask;
    end
    flags_clr = (wr_en && wr_off == OFF_STAT) ? amon_flags_t'(wdata[REG_W-1 -: 4]) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; hi_q <= '0; lo_q <= '0; ahi_q <= '0; alo_q <= '0;
      wt_q <= '0; avg_q <= '0; cnt_q <= '0; flags_q <= '0;
      run_hi_q <= '0; run_lo_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_CTRL: ctrl_q <= wdata;
          OFF_HI:   hi_q   <= wdata;
          OFF_LO:   lo_q   <= wdata;
          OFF_AHI:  ahi_q  <= wdata;
          OFF_ALO:  alo_q  <= wdata;
          OFF_WT:   wt_q   <= wdata;
          default: ;
        endcase
      end
      if (!active) begin
        cnt_q    <= '0;
        run_hi_q <= '0;
        run_lo_q <= '0;
      end else if (boundary) begin
        cnt_q    <= '0;
        run_hi_q <= (above && !hi_fire) ? hi_inc : '0;
        run_lo_q <= (below && !lo_fire) ? lo_inc : '0;
      end else begin
        cnt_q <= sample;
      end
      if (wr_en && wr_off == OFF_INIT) avg_q <= wdata;
      else if (active && boundary)     avg_q <= avg_nxt;
      flags_q <= (flags_q & ~flags_clr) | flags_set;
    end
  end

  always_comb begin
    case (rd_off)
      OFF_CTRL: rd_val = ctrl_q;
      OFF_HI:   rd_val = hi_q;
      OFF_LO:   rd_val = lo_q;
      OFF_AHI:  rd_val = ahi_q;
      OFF_ALO:  rd_val = alo_q;
      OFF_WT:   rd_val = wt_q;
      OFF_AVG:  rd_val = avg_q;
      OFF_STAT: rd_val = {flags_q, {(REG_W-4){1'b0}}};
      default:  rd_val = '0;
    endcase
  end

  assign pend    = |(flags_q & flags_mask);
  assign count_o = cnt_q;
  assign stat_o  = flags_q;
endmodule

// File: rtl/activity_monitor.sv
`timescale 1ns/1ps
module activity_monitor
  import amon_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PER_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic [NCH-1:0]    event_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int BLK_W   = ADDR_W - BLK_LSB;
  localparam int CH_BLK0 = CH_BASE >> BLK_LSB;

  logic                  boundary;
  logic [PER_W-1:0]      per_q, tick_cnt;
  logic                  glb_sel;
  logic [5:0]            off;
  logic [NCH-1:0]        ch_sel, ch_pend, ch_en;
  logic [REG_W-1:0]      ch_rd [NCH];
  logic [NCH-1:0][REG_W-1:0] ch_cnt;
  logic [NCH-1:0][3:0]   ch_stat;
  logic [REG_W-1:0]      gstat, rd_nxt;

  assign off     = reg_addr[BLK_LSB-1:0];
  assign glb_sel = reg_addr[ADDR_W-1:BLK_LSB] == '0;

  amon_period #(.PER_W(PER_W)) u_period (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_we && glb_sel && off == OFF_GPER),
    .wdata    (reg_wdata[PER_W-1:0]),
    .ms_tick  (ms_tick),
    .boundary (boundary),
    .per_q    (per_q),
    .cnt_q    (tick_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_sel[c] = reg_addr[ADDR_W-1:BLK_LSB] == BLK_W'(CH_BLK0 + c);
    amon_channel u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (reg_we && ch_sel[c]),
      .wr_off   (off),
      .wdata    (reg_wdata),
      .rd_off   (off),
      .boundary (boundary),
      .event_i  (event_i[c]),
      .rd_val   (ch_rd[c]),
      .pend     (ch_pend[c]),
      .active   (ch_en[c]),
      .count_o  (ch_cnt[c]),
      .stat_o   (ch_stat[c])
    );
  end

  always_comb begin
    gstat = '0;
    for (int c = 0; c < NCH; c++) gstat[GBIT0 - c] = ch_pend[c];
    rd_nxt = '0;
    if (glb_sel) begin
      if (off == OFF_GSTAT)     rd_nxt = gstat;
      else if (off == OFF_GPER) rd_nxt = {{(REG_W-PER_W){1'b0}}, per_q};
    end else begin
      for (int c = 0; c < NCH; c++) if (ch_sel[c]) rd_nxt = ch_rd[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_nxt;
      irq       <= |ch_pend;
    end
  end
endmodule

// File: rtl/amon_checker.sv
`timescale 1ns/1ps
module amon_checker
  import amon_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PER_W  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ms_tick,
  input logic              boundary,
  input logic [PER_W-1:0]  per_q,
  input logic [PER_W-1:0]  tick_cnt,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              irq,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_pend,
  input logic [NCH-1:0][REG_W-1:0] ch_cnt,
  input logic [NCH-1:0][3:0]       ch_stat
);
  assert_tick_bound_R2: assert property (@(posedge clk) disable iff (rst)
    tick_cnt <= per_q) else $error("tick counter beyond period");

  assert_boundary_tick_R2: assert property (@(posedge clk) disable iff (rst)
    boundary |-> ms_tick) else $error("boundary without tick");

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ch_pend)) else $error("irq without pending channel");

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(CH_BASE + c * (1 << BLK_LSB) + int'(OFF_STAT));

    assert_stop_count_R9: assert property (@(posedge clk) disable iff (rst)
      !ch_en[c] |=> ch_cnt[c] == '0) else $error("stopped channel kept a count");

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (reg_we && reg_addr == SADDR && reg_wdata == '1 && !boundary) |=> ch_stat[c] == 4'b0)
      else $error("status not cleared");
  end
endmodule

bind activity_monitor amon_checker #(.NCH(NCH), .PER_W(PER_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .boundary(boundary), .per_q(per_q),
  .tick_cnt(tick_cnt), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .ch_en(ch_en), .ch_pend(ch_pend), .ch_cnt(ch_cnt), .ch_stat(ch_stat)
);

// File: tb/sim_activity_monitor.sv
`timescale 1ns/1ps
module sim_activity_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic [1:0]  ev = 2'b00;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  activity_monitor u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .event_i(ev), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  // events per period, expected average, expected status (ch0, K=0, weight 10)
  localparam logic [31:0] TBL [8][3] = '{
    '{32'd5,  32'd50, 32'h0000_0000},
    '{32'd12, 32'd85, 32'h8000_0000},
    '{32'd1,  32'd47, 32'h0000_0000},
    '{32'd0,  32'd23, 32'h0000_0000},
    '{32'd1,  32'd16, 32'h4000_0000},
    '{32'd1,  32'd13, 32'h0000_0000},
    '{32'd3,  32'd21, 32'h0000_0000},
    '{32'd15, 32'd85, 32'h8000_0000}
  };

  function automatic longint model_avg(longint avg, longint s, int k);
    longint d = s - avg;
    longint w = longint'(1) << (k + 1);
    if (d >= 0) return avg + d / w;
    return avg - ((-d) + w - 1) / w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(posedge clk); #1; d = rdata;
  endtask

  task automatic period(input int n, input logic [1:0] m);
    for (int i = 0; i < n; i++) begin @(negedge clk); ev = m; end
    @(negedge clk); ev = 2'b00; ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic clear(input logic [11:0] a);
    wr(a, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1; rst = 1'b0;
    // R11 reset state
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    rd(12'h1E0, d); check("R11 avg after reset", d, 32'd0);
    rd(12'h1C0, d); check("R11 ctrl after reset", d, 32'd0);
    rd(12'h004, d); check("R11 period after reset", d, 32'd0);

    // channel 0: weight 10, upper 100, lower 20, band wide open
    wr(12'h1D8, 32'd10);
    wr(12'h1C4, 32'd100);
    wr(12'h1C8, 32'd20);
    wr(12'h1D0, 32'd1000);
    wr(12'h1CC, 32'd50);
    rd(12'h1E0, d); check("R8 init average load", d, 32'd50);
    wr(12'h1C0, 32'hE104_0000);  // above run 1, below run 3, K=0

    for (int v = 0; v < 8; v++) begin
      period(int'(TBL[v][0]), 2'b01);
      rd(12'h1E0, d); check("R1 R3 table average", d, TBL[v][1]);
      rd(12'h1E4, d); check("R4 R5 table status", d, TBL[v][2]);
      check("R10 table irq", {31'd0, irq}, {31'd0, TBL[v][2] != 0});
      clear(12'h1E4);
    end
    check("R7 status cleared irq", {31'd0, irq}, 32'd0);
    rd(12'h1E4, d); check("R7 status cleared", d, 32'd0);

    // R6 band top
    wr(12'h1D0, 32'd90);
    wr(12'h1C0, 32'hE124_0000);
    period(12, 2'b01);
    rd(12'h1E0, d); check("R6 average", d, 32'd102);
    rd(12'h1E4, d); check("R6 band and run flags", d, 32'hA000_0000);
    clear(12'h1E4);

    // R3 with K=2
    wr(12'h1D0, 32'hFFFF_FFFF);
    wr(12'h1C0, 32'hE124_0800);
    wr(12'h1CC, 32'd100);
    period(2, 2'b01);
    rd(12'h1E0, d); check("R3 K=2 average", d, 32'(model_avg(100, 20, 2)));
    rd(12'h1E4, d); check("R4 R5 equal to watermark is no breach", d, 32'd0);

    // R10 mask follows current enable
    period(15, 2'b01);
    rd(12'h1E0, d); check("R3 K=2 rising average", d, 32'(model_avg(90, 150, 2)));
    check("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(12'h1C0, 32'hA124_0800);
    @(negedge clk);
    check("R10 irq masked by enable", {31'd0, irq}, 32'd0);
    rd(12'h1E4, d); check("R10 raw status kept", d, 32'h8000_0000);
    clear(12'h1E4);

    // R9 stop
    wr(12'h1C0, 32'h0);
    period(20, 2'b01);
    rd(12'h1E0, d); check("R9 stopped average holds", d, 32'd97);
    rd(12'h1E4, d); check("R9 stopped status", d, 32'd0);
    check("R9 stopped irq", {31'd0, irq}, 32'd0);

    // R10 second channel global bit
    wr(12'h204, 32'd5);
    wr(12'h218, 32'd1);
    wr(12'h200, 32'hC004_0000);
    period(10, 2'b10);
    rd(12'h000, d); check("R10 global status bit 25", d, 32'h0200_0000);
    check("R10 irq from channel 1", {31'd0, irq}, 32'd1);
    rd(12'h220, d); check("R3 channel 1 average", d, 32'd5);
    clear(12'h224);
    rd(12'h000, d); check("R10 global status cleared", d, 32'd0);

    // R2 period of three ticks, R1 accumulation across ticks
    wr(12'h004, 32'd2);
    rd(12'h004, d); check("R2 period readback", d, 32'd2);
    period(4, 2'b10);
    period(0, 2'b10);
    rd(12'h220, d); check("R2 no boundary before third tick", d, 32'd5);
    period(0, 2'b10);
    rd(12'h220, d); check("R1 R2 boundary on third tick", d, 32'(model_avg(5, 4, 0)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule